// File: doc/BRIEF.md
# Three-multiplier complex twiddle multiplier

This block forms the complex product of a signed sample x + jy and a twiddle coefficient c + js. It is meant to sit after the difference path of a radix-2 FFT butterfly. The coefficient is never presented as a cosine/sine pair. Instead, a coefficient store supplies three words: c, the pre-added sum c+s and the pre-subtracted difference c-s.

With those three words the block builds one shared term, t = c·(x − y). The real part is then (c − s)·y + t and the imaginary part is (c + s)·x − t. A full complex multiply therefore costs three real multipliers instead of four.

The block has a two-stage pipeline. The first stage registers the operands. The second stage registers the scaled results. Each result is the full-precision value shifted right arithmetically by the number of coefficient fraction bits and then truncated to the sample width. A coefficient value of 128 stands for 1.0. Nothing saturates: an out-of-range result wraps.

Top module: `cplx_twiddle_mul3`

## Requirements
- R1: `prod_re_o` equals the low 8 bits of (c·x − s·y) arithmetically shifted right by 7, where s = (c+s word) − c.
- R2: `prod_im_o` equals the low 8 bits of (s·x + c·y) arithmetically shifted right by 7.
- R3: The coefficient enters only as c (8-bit signed), c+s (9-bit signed) and c−s (9-bit signed). With c held fixed, changing s through those two wider words changes both outputs as R1 and R2 predict.
- R4: An operand set applied before rising edge k appears on both outputs after edge k+1. A new operand set is accepted on every edge, and after edge k alone the outputs still show the earlier result.
- R5: While `rst_n` is low on a rising edge, both outputs read 0 after that edge.
- R6: Scaling rounds toward minus infinity. For example x = −1, y = 0, c = 1, s = 0 gives a real result of −1, and x = 1 gives 0.
- R7: With the coefficient c = 127, c+s = 127, c−s = 127, each output is within one LSB of the matching input part.
- R8: For extreme inputs (x, y each −128 or +127), results follow R1/R2 with wrap-around in 8 bits. For example x = −128, y = 0, c = −128, s = 0 gives a real result of −128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of both pipeline stages |
| samp_re_i | input | 8 | Sample real part x, signed |
| samp_im_i | input | 8 | Sample imaginary part y, signed |
| coef_c_i | input | 8 | Coefficient c, signed, 7 fraction bits |
| coef_sum_i | input | 9 | Pre-added coefficient c+s, signed |
| coef_dif_i | input | 9 | Pre-subtracted coefficient c−s, signed |
| prod_re_o | output | 8 | Registered real part of the scaled product |
| prod_im_o | output | 8 | Registered imaginary part of the scaled product |

## Verification
Random samples and coefficients exercise the general identity between the shared-term form and the four-product reference. Sweeping s while c is fixed shows that the c+s and c−s words are really used, and not c alone. Small values around zero separate floor-style truncation from rounding toward zero. The corner sweep puts −128 and +127 on both sample parts against unity, negative-full-scale and equal-part coefficients. It exposes any lost sign-extension bit in x − y or in the accumulation, and it confirms the 8-bit wrap.

// File: rtl/twm_pkg.sv
package twm_pkg;

   // Which of the two output lanes a lane instance implements
   typedef enum logic {
      LANE_RE = 1'b0,
      LANE_IM = 1'b1
   } lane_e;

   localparam int NUM_LANES = 2;

endpackage

// File: rtl/twm_stage_reg.sv
module twm_stage_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("twm_stage_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_o <= '0;
      end else begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/twm_cmul.sv
module twm_cmul #(
   parameter int A_W = 9,
   parameter int B_W = 8,
   parameter int P_W = 17
) (
   input  logic signed [A_W-1:0] a_i,
   input  logic signed [B_W-1:0] b_i,
   output logic signed [P_W-1:0] p_o
);

   localparam int FULL_W = A_W + B_W;

   if (P_W < FULL_W) begin : g_bad_pw
      $error("twm_cmul: P_W narrower than the exact product");
   end

   logic signed [FULL_W-1:0] full;

   assign full = a_i * b_i;

   if (P_W == FULL_W) begin : g_exact
      assign p_o = full;
   end else begin : g_extend
      assign p_o = {{(P_W-FULL_W){full[FULL_W-1]}}, full};
   end

endmodule

// File: rtl/twm_lane.sv
module twm_lane
   import twm_pkg::*;
#(
   parameter lane_e LANE      = LANE_RE,
   parameter int    PROD_W    = 17,
   parameter int    FRAC_BITS = 7,
   parameter int    OUT_W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [PROD_W-1:0] own_p_i,
   input  logic signed [PROD_W-1:0] shared_i,
   output logic signed [OUT_W-1:0]  res_o
);

   // One guard bit so the sum or difference of two products never overflows
   localparam int ACC_W = PROD_W + 1;
   localparam int TOP   = FRAC_BITS + OUT_W;

   if (TOP >= ACC_W) begin : g_bad_fit
      $error("twm_lane: FRAC_BITS + OUT_W must stay below the accumulator width");
   end
   if (FRAC_BITS < 1) begin : g_bad_frac
      $error("twm_lane: FRAC_BITS must be at least one");
   end

   logic signed [ACC_W-1:0] own_x;
   logic signed [ACC_W-1:0] shr_x;
   logic signed [ACC_W-1:0] acc;
   logic signed [OUT_W-1:0] scaled;
   logic                    unused_acc_bits;

   assign own_x = {own_p_i[PROD_W-1], own_p_i};
   assign shr_x = {shared_i[PROD_W-1], shared_i};

   if (LANE == LANE_RE) begin : g_add
      assign acc = own_x + shr_x;
   end else begin : g_sub
      assign acc = own_x - shr_x;
   end

   // Arithmetic shift then truncation: keep the bit window above the fraction
   assign scaled          = acc[TOP-1:FRAC_BITS];
   assign unused_acc_bits = ^{acc[FRAC_BITS-1:0], acc[ACC_W-1:TOP]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o <= '0;
      end else begin
         res_o <= scaled;
      end
   end

endmodule

// File: rtl/cplx_twiddle_mul3.sv
module cplx_twiddle_mul3
   import twm_pkg::*;
#(
   parameter int SAMP_W    = 8,
   parameter int COEF_W    = 8,
   parameter int PROD_W    = 17,
   parameter int FRAC_BITS = 7,
   parameter int OUT_W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic signed [SAMP_W-1:0]   samp_re_i,
   input  logic signed [SAMP_W-1:0]   samp_im_i,
   input  logic signed [COEF_W-1:0]   coef_c_i,
   input  logic signed [COEF_W:0]     coef_sum_i,
   input  logic signed [COEF_W:0]     coef_dif_i,
   output logic signed [OUT_W-1:0]    prod_re_o,
   output logic signed [OUT_W-1:0]    prod_im_o
);

   localparam int SUM_W  = COEF_W + 1;
   localparam int DIFF_W = SAMP_W + 1;
   localparam int IN_W   = 2 * SAMP_W + COEF_W + 2 * SUM_W;

   if (PROD_W < SUM_W + SAMP_W) begin : g_bad_prod
      $error("cplx_twiddle_mul3: PROD_W cannot hold a coefficient-sum product");
   end
   if (PROD_W < COEF_W + DIFF_W) begin : g_bad_shared
      $error("cplx_twiddle_mul3: PROD_W cannot hold the shared product");
   end
   if (OUT_W > PROD_W - FRAC_BITS) begin : g_bad_out
      $error("cplx_twiddle_mul3: OUT_W exceeds the integer part of a product");
   end

   // ---------------- stage 1: operand registers ----------------
   logic [IN_W-1:0] in_bus;
   logic [IN_W-1:0] in_q;

   assign in_bus = {samp_re_i, samp_im_i, coef_c_i, coef_sum_i, coef_dif_i};

   twm_stage_reg #(.W(IN_W)) u_in_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (in_bus),
      .q_o   (in_q)
   );

   logic signed [SAMP_W-1:0] r_x;
   logic signed [SAMP_W-1:0] r_y;
   logic signed [COEF_W-1:0] r_c;
   logic signed [SUM_W-1:0]  r_csum;
   logic signed [SUM_W-1:0]  r_cdif;

   assign {r_x, r_y, r_c, r_csum, r_cdif} = in_q;

   // ---------------- shared term c*(x-y) ----------------
   logic signed [DIFF_W-1:0] xy_diff;
   logic signed [PROD_W-1:0] shared_t;

   assign xy_diff = {r_x[SAMP_W-1], r_x} - {r_y[SAMP_W-1], r_y};

   twm_cmul #(.A_W(COEF_W), .B_W(DIFF_W), .P_W(PROD_W)) u_shared_mul (
      .a_i (r_c),
      .b_i (xy_diff),
      .p_o (shared_t)
   );

   // ---------------- per-lane product and stage 2 ----------------
   logic signed [PROD_W-1:0] own_p [NUM_LANES];
   logic signed [OUT_W-1:0]  res   [NUM_LANES];

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam lane_e L = (g == 0) ? LANE_RE : LANE_IM;

      logic signed [SUM_W-1:0]  k_sel;
      logic signed [SAMP_W-1:0] v_sel;

      if (L == LANE_RE) begin : g_re_ops
         assign k_sel = r_cdif;
         assign v_sel = r_y;
      end else begin : g_im_ops
         assign k_sel = r_csum;
         assign v_sel = r_x;
      end

      twm_cmul #(.A_W(SUM_W), .B_W(SAMP_W), .P_W(PROD_W)) u_mul (
         .a_i (k_sel),
         .b_i (v_sel),
         .p_o (own_p[g])
      );

      twm_lane #(
         .LANE      (L),
         .PROD_W    (PROD_W),
         .FRAC_BITS (FRAC_BITS),
         .OUT_W     (OUT_W)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .own_p_i  (own_p[g]),
         .shared_i (shared_t),
         .res_o    (res[g])
      );
   end

   assign prod_re_o = res[0];
   assign prod_im_o = res[1];

endmodule

// File: rtl/twm_check.sv
module twm_check #(
   parameter int SAMP_W    = 8,
   parameter int COEF_W    = 8,
   parameter int FRAC_BITS = 7,
   parameter int OUT_W     = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic signed [SAMP_W-1:0] samp_re_i,
   input logic signed [SAMP_W-1:0] samp_im_i,
   input logic signed [COEF_W-1:0] coef_c_i,
   input logic signed [COEF_W:0]   coef_sum_i,
   input logic signed [COEF_W:0]   coef_dif_i,
   input logic signed [OUT_W-1:0]  prod_re_o,
   input logic signed [OUT_W-1:0]  prod_im_o
);

   localparam int UNITY = (1 << FRAC_BITS) - 1;

   // Cycles since reset release, saturating at the pipeline depth
   logic [1:0] warm;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         warm <= 2'd0;
      end else if (warm != 2'd2) begin
         warm <= warm + 2'd1;
      end
   end

   logic armed;
   assign armed = (warm == 2'd2);

   function automatic int trunc_out(input int v);
      int                      sh;
      logic signed [OUT_W-1:0] n;
      sh = v >>> FRAC_BITS;
      n  = OUT_W'(sh);
      return int'(n);
   endfunction

   // Four-product reference; the sine is recovered from the sum word
   function automatic int ref_re(input int x, input int y, input int c, input int cps);
      return trunc_out(c * x - (cps - c) * y);
   endfunction

   function automatic int ref_im(input int x, input int y, input int c, input int cps);
      return trunc_out((cps - c) * x + c * y);
   endfunction

   function automatic bit coef_ok(input int c, input int cps, input int cms);
      return (cps + cms) == 2 * c;
   endfunction

   // R5: reset clears both results
   p_reset_clear_r5: assert property (@(posedge clk)
      !rst_n |=> (prod_re_o == '0 && prod_im_o == '0));

   // R1: real part matches the four-product reference two edges later
   p_real_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && coef_ok(int'($past(coef_c_i, 2)), int'($past(coef_sum_i, 2)), int'($past(coef_dif_i, 2))))
      |-> (int'(prod_re_o) == ref_re(int'($past(samp_re_i, 2)), int'($past(samp_im_i, 2)),
                                     int'($past(coef_c_i, 2)), int'($past(coef_sum_i, 2)))));

   // R2: imaginary part matches the four-product reference two edges later
   p_imag_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && coef_ok(int'($past(coef_c_i, 2)), int'($past(coef_sum_i, 2)), int'($past(coef_dif_i, 2))))
      |-> (int'(prod_im_o) == ref_im(int'($past(samp_re_i, 2)), int'($past(samp_im_i, 2)),
                                     int'($past(coef_c_i, 2)), int'($past(coef_sum_i, 2)))));

   // R7: unity coefficient passes the sample through within one LSB
   p_unity_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && int'($past(coef_c_i, 2)) == UNITY && int'($past(coef_sum_i, 2)) == UNITY
             && int'($past(coef_dif_i, 2)) == UNITY)
      |-> ((int'(prod_re_o) - int'($past(samp_re_i, 2))) inside {-1, 0, 1} &&
           (int'(prod_im_o) - int'($past(samp_im_i, 2))) inside {-1, 0, 1}));

endmodule

bind cplx_twiddle_mul3 twm_check #(
   .SAMP_W    (SAMP_W),
   .COEF_W    (COEF_W),
   .FRAC_BITS (FRAC_BITS),
   .OUT_W     (OUT_W)
) u_twm_check (
   .clk        (clk),
   .rst_n      (rst_n),
   .samp_re_i  (samp_re_i),
   .samp_im_i  (samp_im_i),
   .coef_c_i   (coef_c_i),
   .coef_sum_i (coef_sum_i),
   .coef_dif_i (coef_dif_i),
   .prod_re_o  (prod_re_o),
   .prod_im_o  (prod_im_o)
);

// File: tb/cplx_twiddle_mul3_tb_top.sv
module cplx_twiddle_mul3_tb_top;

   localparam int FRAC = 7;
   localparam int WATCHDOG_CYCLES = 50000;

   logic              clk;
   logic              rst_n;
   logic signed [7:0] x_d;
   logic signed [7:0] y_d;
   logic signed [7:0] c_d;
   logic signed [8:0] cps_d;
   logic signed [8:0] cms_d;
   logic signed [7:0] re_q;
   logic signed [7:0] im_q;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // Expected results in flight, oldest first
   int    q_re  [$];
   int    q_im  [$];
   int    q_x   [$];
   int    q_y   [$];
   bit    q_uni [$];
   string q_tag [$];

   cplx_twiddle_mul3 dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_re_i  (x_d),
      .samp_im_i  (y_d),
      .coef_c_i   (c_d),
      .coef_sum_i (cps_d),
      .coef_dif_i (cms_d),
      .prod_re_o  (re_q),
      .prod_im_o  (im_q)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic int wrap8(input int v);
      int  sh;
      byte b;
      sh = v >>> FRAC;
      b  = byte'(sh);
      return int'(b);
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // Compare the oldest expectation once it has crossed both pipeline edges
   task automatic compare_out();
      if (q_re.size() >= 2) begin
         int  e_re = q_re.pop_front();
         int  e_im = q_im.pop_front();
         int  ex   = q_x.pop_front();
         int  ey   = q_y.pop_front();
         bit  uni  = q_uni.pop_front();
         string t  = q_tag.pop_front();
         check({t, "/R1 real"}, int'(re_q), e_re);
         check({t, "/R2 imag"}, int'(im_q), e_im);
         if (uni) begin
            int dr = int'(re_q) - ex;
            int di = int'(im_q) - ey;
            check("R7 real within 1 LSB", (dr >= -1 && dr <= 1) ? 1 : 0, 1);
            check("R7 imag within 1 LSB", (di >= -1 && di <= 1) ? 1 : 0, 1);
         end
      end else if (q_re.size() == 1) begin
         // One edge after the first operand set: outputs still show the reset value
         check("R4 not yet updated real", int'(re_q), 0);
         check("R4 not yet updated imag", int'(im_q), 0);
      end
   endtask

   task automatic step(input int x, input int y, input int c, input int s, input string tag);
      @(negedge clk);
      compare_out();
      x_d   = 8'(x);
      y_d   = 8'(y);
      c_d   = 8'(c);
      cps_d = 9'(c + s);
      cms_d = 9'(c - s);
      q_re.push_back(wrap8(c * x - s * y));
      q_im.push_back(wrap8(s * x + c * y));
      q_x.push_back(x);
      q_y.push_back(y);
      q_uni.push_back((c == 127 && s == 0) ? 1'b1 : 1'b0);
      q_tag.push_back(tag);
   endtask

   function automatic int rnd8();
      return int'($urandom_range(255)) - 128;
   endfunction

   initial begin : watchdog
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : stimulus
      int corner [2];
      int cs_c [6];
      int cs_s [6];
      corner = '{-128, 127};
      cs_c   = '{127, -128, 0, -128, 127, 90};
      cs_s   = '{0, 0, 127, -128, 127, -90};

      rst_n = 1'b0;
      x_d = 8'sd55; y_d = -8'sd33; c_d = 8'sd100; cps_d = 9'sd150; cms_d = 9'sd50;
      repeat (3) @(negedge clk);
      check("R5 reset real", int'(re_q), 0);
      check("R5 reset imag", int'(im_q), 0);
      x_d = '0; y_d = '0; c_d = '0; cps_d = '0; cms_d = '0;
      rst_n = 1'b1;

      // R4: back-to-back distinct operands, one per cycle, first gives a nonzero result
      step(100, -50, 90, 90, "R4");
      step(-77, 12, -64, 100, "R4");
      step(5, 120, 127, -127, "R4");

      // R1, R2: random operands
      for (int i = 0; i < 200; i++) begin
         step(rnd8(), rnd8(), rnd8(), rnd8(), "R1R2");
      end

      // R3: fixed c, sweep s through the sum and difference words
      for (int s = -128; s <= 127; s += 17) begin
         step(91, -46, 70, s, "R3");
      end

      // R6: floor-style truncation near zero
      step(-1, 0, 1, 0, "R6");
      step(1, 0, 1, 0, "R6");
      step(0, -1, 1, 0, "R6");
      step(-1, -1, 1, 1, "R6");

      // R7: unity coefficient across a spread of samples
      for (int v = -128; v <= 127; v += 15) begin
         step(v, -v - 1, 127, 0, "R7");
      end
      step(-128, 127, 127, 0, "R7");
      step(127, -128, 127, 0, "R7");

      // R8: extremes on both sample parts against several coefficients
      for (int k = 0; k < 6; k++) begin
         for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
               step(corner[a], corner[b], cs_c[k], cs_s[k], "R8");
            end
         end
      end
      step(-128, 0, -128, 0, "R8 wrap");

      // Drain the pipeline
      step(0, 0, 0, 0, "flush");
      step(0, 0, 0, 0, "flush");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule